// File: doc/BRIEF.md
# Dual-Source Boot Mode Control Register

This block holds the settings that choose what a microcontroller does when it leaves reset. There are two settings: a boot-enable bit and a two-bit programming-source select. Each setting is kept twice. One copy is written by the CPU through a plain register write port. The other copy is loaded by a debug-port update strobe. Each effective setting, and each bit the CPU reads back, is the OR of the two copies. A CPU write clears the debug-port copy of the source select. A debug-disable input clears the debug-port copy of the boot-enable bit.

When any reset is released, the block samples the effective settings. It then holds a boot decision for the reset sequencer: either jump to the application at address zero, or run the bootloader. When the bootloader is chosen, it also holds a decoded programming interface. The settings themselves survive ordinary system resets. Only a power-on reset or a test-logic reset clears them. That is how firmware or a debugger can arrange a bootloader entry across a warm reset. Bit 0 of the read value is an external transfer-complete status that the block only passes through.

Top module: `boot_mode_ctrl`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it is released, `cpu_rd_data` bits 7:1 read 0 and all four decision outputs are 0.
- R2: `cpu_rd_data` bits 7:4 always read 0, and bit 0 always equals `txc_in` in the same cycle.
- R3: `cpu_rd_data` bits 3:2 (source select) read the bitwise OR of the CPU copy (from `cpu_wr_data` bits 3:2) and the debug copy (from `dbg_data` bits 1:0).
- R4: `cpu_rd_data` bit 1 (boot enable) reads the OR of the CPU copy (from `cpu_wr_data` bit 1) and the debug copy (from `dbg_data` bit 2).
- R5: Every CPU write clears the debug copy of the source select. This also holds when `dbg_upd` is high in the same cycle: the debug boot-enable bit still loads, but the debug source-select bits end at 0.
- R6: While `rod` is high, the debug copy of boot enable is cleared, and this overrides a `dbg_upd` in the same cycle. The CPU copy is unaffected.
- R7: Pulsing `por_n` low or `tlr_n` low clears both copies of all settings. Pulsing `sys_rst_n` low leaves both copies unchanged.
- R8: When any reset is released, `boot_loader` takes the effective boot-enable value, with 1 meaning bootloader and 0 meaning application at address zero. It then holds that value until the next release, whatever is written later.
- R9: The source outputs are sampled at the same moment as `boot_loader`. With boot enable set, an effective select of 00 raises `src_jtag`, 01 raises `src_uart`, and 10 or 11 raises `src_invalid`. With boot enable clear, all three are 0. At most one of them is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| tlr_n | input | 1 | Test-logic reset, asynchronous, active low |
| sys_rst_n | input | 1 | Ordinary system reset, asynchronous, active low; does not clear the settings |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_wr_data | input | 8 | CPU write data; bits 3:2 source select, bit 1 boot enable |
| cpu_rd_data | output | 8 | CPU read value |
| dbg_upd | input | 1 | Debug-port update strobe |
| dbg_data | input | 3 | Debug-port data; bit 2 boot enable, bits 1:0 source select |
| rod | input | 1 | Debug-disable; clears the debug boot-enable copy |
| txc_in | input | 1 | Transfer-complete status shown at read bit 0 |
| boot_loader | output | 1 | Held decision: 1 bootloader, 0 application at address zero |
| src_jtag | output | 1 | Held decision: program through JTAG |
| src_uart | output | 1 | Held decision: program through UART |
| src_invalid | output | 1 | Held decision: reserved source selected |

## Verification
Assertions check four things on every cycle:
- a CPU write reads back its own source select on the next cycle;
- the debug-disable input leaves only the CPU boot-enable copy in effect;
- the held decision changes only in the cycle after a reset release, and then matches the effective boot enable;
- the source outputs are at most one-hot and are all clear on the application path.

Only the bench's scenarios can show three other things. The first is that the OR read-back is correct for every pair of CPU and debug values. The second is which reset kinds clear or keep the settings. The third is the exact cycle at which a decision appears after a release. The bench sweeps all 64 pairs of 3-bit CPU and debug settings through a warm reset.

// File: rtl/bootctl_pkg.sv
package bootctl_pkg;
  localparam int REG_W   = 8;
  localparam int TXC_BIT = 0;
  localparam int BEN_BIT = 1;
  localparam int SEL_LSB = 2;
  localparam int SEL_W   = 2;
  localparam int DBG_W   = SEL_W + 1;
  localparam int DBG_BEN = SEL_W;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_JTAG = 2'd1,
    SRC_UART = 2'd2,
    SRC_BAD  = 2'd3
  } boot_src_e;
endpackage

// File: rtl/bootctl_rst_sync.sv
module bootctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/bootctl_fields.sv
module bootctl_fields
  import bootctl_pkg::*;
(
  input  logic             clk,
  input  logic             cfg_rst_n,
  input  logic             cpu_wr,
  input  logic             wr_ben,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             dbg_upd,
  input  logic [DBG_W-1:0] dbg_data,
  input  logic             rod,
  output logic             eff_ben,
  output logic [SEL_W-1:0] eff_sel
);
  logic             cpu_ben_q, cpu_ben_d;
  logic [SEL_W-1:0] cpu_sel_q, cpu_sel_d;
  logic             dbg_ben_q, dbg_ben_d;
  logic [SEL_W-1:0] dbg_sel_q, dbg_sel_d;

  always_comb begin
    cpu_ben_d = cpu_ben_q;
    cpu_sel_d = cpu_sel_q;
    if (cpu_wr) begin
      cpu_ben_d = wr_ben;
      cpu_sel_d = wr_sel;
    end
    dbg_ben_d = dbg_ben_q;
    if (rod)          dbg_ben_d = 1'b0;
    else if (dbg_upd) dbg_ben_d = dbg_data[DBG_BEN];
    dbg_sel_d = dbg_sel_q;
    if (cpu_wr)       dbg_sel_d = '0;
    else if (dbg_upd) dbg_sel_d = dbg_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      cpu_ben_q <= 1'b0;
      cpu_sel_q <= '0;
      dbg_ben_q <= 1'b0;
      dbg_sel_q <= '0;
    end else begin
      cpu_ben_q <= cpu_ben_d;
      cpu_sel_q <= cpu_sel_d;
      dbg_ben_q <= dbg_ben_d;
      dbg_sel_q <= dbg_sel_d;
    end
  end

  assign eff_ben = cpu_ben_q | dbg_ben_q;
  assign eff_sel = cpu_sel_q | dbg_sel_q;

  AST_WR_SEL_EXACT: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    cpu_wr |=> (eff_sel == $past(wr_sel))); // R5
  AST_ROD_DROPS_DBG: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    rod |=> (eff_ben == cpu_ben_q)); // R6
endmodule

// File: rtl/bootctl_decide.sv
module bootctl_decide
  import bootctl_pkg::*;
(
  input  logic             clk,
  input  logic             cfg_rst_n,
  input  logic             any_rst_n,
  input  logic             eff_ben,
  input  logic [SEL_W-1:0] eff_sel,
  output logic             boot_loader,
  output logic             src_jtag,
  output logic             src_uart,
  output logic             src_invalid
);
  logic      seen_q;
  logic      release_pulse;
  logic      ldr_q, ldr_d;
  boot_src_e src_q, src_d;
  boot_src_e src_pick;

  always_ff @(posedge clk or negedge any_rst_n) begin
    if (!any_rst_n) seen_q <= 1'b0;
    else            seen_q <= 1'b1;
  end

  assign release_pulse = any_rst_n & ~seen_q;

  always_comb begin
    if (!eff_ben)                src_pick = SRC_NONE;
    else if (eff_sel[SEL_W-1])   src_pick = SRC_BAD;
    else if (eff_sel[0])         src_pick = SRC_UART;
    else                         src_pick = SRC_JTAG;
    ldr_d = ldr_q;
    src_d = src_q;
    if (release_pulse) begin
      ldr_d = eff_ben;
      src_d = src_pick;
    end
  end

  always_ff @(posedge clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      ldr_q <= 1'b0;
      src_q <= SRC_NONE;
    end else begin
      ldr_q <= ldr_d;
      src_q <= src_d;
    end
  end

  assign boot_loader = ldr_q;
  assign src_jtag    = (src_q == SRC_JTAG);
  assign src_uart    = (src_q == SRC_UART);
  assign src_invalid = (src_q == SRC_BAD);

  AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    !release_pulse |=> ($stable(boot_loader) && $stable(src_q))); // R8
  AST_DECISION_TAKEN: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    release_pulse |=> (boot_loader == $past(eff_ben))); // R8
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    $onehot0({src_jtag, src_uart, src_invalid})); // R9
  AST_APP_NO_SRC: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    !boot_loader |-> !(src_jtag || src_uart || src_invalid)); // R9
endmodule

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl
  import bootctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tlr_n,
  input  logic             sys_rst_n,
  input  logic             cpu_wr_en,
  input  logic [REG_W-1:0] cpu_wr_data,
  output logic [REG_W-1:0] cpu_rd_data,
  input  logic             dbg_upd,
  input  logic [DBG_W-1:0] dbg_data,
  input  logic             rod,
  input  logic             txc_in,
  output logic             boot_loader,
  output logic             src_jtag,
  output logic             src_uart,
  output logic             src_invalid
);
  logic             cfg_rst_n;
  logic             any_rst_n;
  logic             eff_ben;
  logic [SEL_W-1:0] eff_sel;
  logic             wr_unused;

  assign wr_unused = ^{cpu_wr_data[REG_W-1:SEL_LSB+SEL_W], cpu_wr_data[TXC_BIT]};

  bootctl_rst_sync #(.STAGES(SYNC_STAGES)) u_cfg_sync (
    .clk(clk), .arst_n(por_n & tlr_n), .srst_n(cfg_rst_n));

  bootctl_rst_sync #(.STAGES(SYNC_STAGES)) u_any_sync (
    .clk(clk), .arst_n(por_n & tlr_n & sys_rst_n), .srst_n(any_rst_n));

  bootctl_fields u_fields (
    .clk(clk), .cfg_rst_n(cfg_rst_n),
    .cpu_wr(cpu_wr_en),
    .wr_ben(cpu_wr_data[BEN_BIT]),
    .wr_sel(cpu_wr_data[SEL_LSB +: SEL_W]),
    .dbg_upd(dbg_upd), .dbg_data(dbg_data), .rod(rod),
    .eff_ben(eff_ben), .eff_sel(eff_sel));

  bootctl_decide u_decide (
    .clk(clk), .cfg_rst_n(cfg_rst_n), .any_rst_n(any_rst_n),
    .eff_ben(eff_ben), .eff_sel(eff_sel),
    .boot_loader(boot_loader), .src_jtag(src_jtag),
    .src_uart(src_uart), .src_invalid(src_invalid));

  always_comb begin
    cpu_rd_data                   = '0;
    cpu_rd_data[TXC_BIT]          = txc_in;
    cpu_rd_data[BEN_BIT]          = eff_ben;
    cpu_rd_data[SEL_LSB +: SEL_W] = eff_sel;
  end

  AST_READ_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!cfg_rst_n)
    (cpu_rd_data[REG_W-1:SEL_LSB+SEL_W] == '0) && (cpu_rd_data[TXC_BIT] == txc_in)); // R2
endmodule

// File: tb/tb_boot_mode_ctrl.sv
module tb_boot_mode_ctrl;
  logic       clk = 1'b0;
  logic       por_n, tlr_n, sys_rst_n;
  logic       cpu_wr_en;
  logic [7:0] cpu_wr_data;
  logic [7:0] cpu_rd_data;
  logic       dbg_upd;
  logic [2:0] dbg_data;
  logic       rod, txc_in;
  logic       boot_loader, src_jtag, src_uart, src_invalid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  boot_mode_ctrl dut (
    .clk(clk), .por_n(por_n), .tlr_n(tlr_n), .sys_rst_n(sys_rst_n),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .cpu_rd_data(cpu_rd_data),
    .dbg_upd(dbg_upd), .dbg_data(dbg_data), .rod(rod), .txc_in(txc_in),
    .boot_loader(boot_loader), .src_jtag(src_jtag), .src_uart(src_uart),
    .src_invalid(src_invalid));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [2:0] sel_ben);
    cpu_wr_data = {4'b0, sel_ben[2:1], sel_ben[0], 1'b0};
    cpu_wr_en = 1'b1;
    tick(1);
    cpu_wr_en = 1'b0;
  endtask

  task automatic dbg_load(input logic [2:0] d);
    dbg_data = d;
    dbg_upd  = 1'b1;
    tick(1);
    dbg_upd  = 1'b0;
  endtask

  task automatic pulse_reset(input int kind);
    if (kind == 0) por_n = 1'b0;
    else if (kind == 1) tlr_n = 1'b0;
    else sys_rst_n = 1'b0;
    tick(2);
    por_n = 1'b1; tlr_n = 1'b1; sys_rst_n = 1'b1;
    tick(5);
  endtask

  function automatic logic [7:0] dec_exp(input logic ben, input logic [1:0] sel);
    if (!ben)        return 8'b0000;
    else if (sel[1]) return 8'b1001;
    else if (sel[0]) return 8'b1010;
    else             return 8'b1100;
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] dexp;
    por_n = 1'b0; tlr_n = 1'b1; sys_rst_n = 1'b1;
    cpu_wr_en = 1'b0; cpu_wr_data = '0; dbg_upd = 1'b0; dbg_data = '0;
    rod = 1'b0; txc_in = 1'b1;
    tick(3);
    chk("R1 read in reset", cpu_rd_data & 8'hFE, 8'h00);
    chk("R1 decision in reset", {4'b0, boot_loader, src_jtag, src_uart, src_invalid}, 8'h00);
    por_n = 1'b1;
    tick(1);
    chk("R1 read after release", cpu_rd_data & 8'hFE, 8'h00);
    tick(4);
    chk("R1 decision after release", {4'b0, boot_loader, src_jtag, src_uart, src_invalid}, 8'h00);
    chk("R2 txc high", {7'b0, cpu_rd_data[0]}, 8'h01);
    txc_in = 1'b0;
    tick(1);
    chk("R2 txc low", {7'b0, cpu_rd_data[0]}, 8'h00);

    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 8; d++) begin
        logic [1:0] sel;
        logic       ben;
        pulse_reset((c + d) % 2);
        chk("R7 cleared by por/tlr", cpu_rd_data & 8'hFE, 8'h00);
        txc_in = c[0] ^ d[1];
        cpu_write(c[2:0]);
        dbg_load(d[2:0]);
        sel = c[2:1] | d[1:0];
        ben = c[0] | d[2];
        chk("R3 R4 read is OR", cpu_rd_data, {4'b0, sel, ben, txc_in});
        chk("R8 decision held before release",
            {4'b0, boot_loader, src_jtag, src_uart, src_invalid}, 8'h00);
        pulse_reset(2);
        chk("R7 kept across sys reset", cpu_rd_data, {4'b0, sel, ben, txc_in});
        dexp = dec_exp(ben, sel);
        chk("R8 R9 decision at release",
            {4'b0, boot_loader, src_jtag, src_uart, src_invalid}, dexp);
        cpu_write(3'b000);
        chk("R5 write clears debug select", cpu_rd_data, {4'b0, 2'b00, d[2], txc_in});
        chk("R8 decision held after write",
            {4'b0, boot_loader, src_jtag, src_uart, src_invalid}, dexp);
      end
    end

    pulse_reset(0);
    txc_in = 1'b0;
    cpu_wr_data = 8'b0000_0100;
    dbg_data = 3'b110;
    cpu_wr_en = 1'b1; dbg_upd = 1'b1;
    tick(1);
    cpu_wr_en = 1'b0; dbg_upd = 1'b0;
    chk("R5 same-cycle write wins on select", cpu_rd_data, 8'b0000_0110);

    pulse_reset(1);
    dbg_load(3'b100);
    chk("R4 debug enable alone", cpu_rd_data, 8'b0000_0010);
    rod = 1'b1;
    tick(1);
    rod = 1'b0;
    chk("R6 rod clears debug enable", cpu_rd_data, 8'b0000_0000);
    cpu_write(3'b001);
    dbg_data = 3'b100; dbg_upd = 1'b1; rod = 1'b1;
    tick(1);
    dbg_upd = 1'b0; rod = 1'b0;
    chk("R6 rod beats update, cpu copy kept", cpu_rd_data, 8'b0000_0010);
    cpu_write(3'b000);
    chk("R6 debug enable stays cleared", cpu_rd_data, 8'b0000_0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule